// File: doc/BRIEF.md
# Processor-to-ISA I/O Window Bridge

This block sits between a processor load/store port and an ISA-style I/O port bus. Processor accesses that land in an 8 MB window starting at 0x80000000 are turned into port-bus cycles. Accesses anywhere else are refused with a miss flag. Each access carries a 32-bit address, a size code, a write flag and right-justified write data. The bridge drives a 16-bit port address, the data with its byte lanes corrected, and a one-cycle strobe. It then returns the read data together with a one-cycle completion pulse.

Two mode inputs come from the system control bank. The first picks how window addresses fold into port space. In the dense map the port address is simply the low half of the processor address. In the sparse map, scattered 4 KB pages are packed into a compact port range. The second mode input tells the bridge that the processor is big-endian, so multi-byte data must be byte-reversed in both directions. The bridge samples both mode inputs, with the request, in the cycle it accepts the access.

The bridge is run by a four-state controller:
- IDLE waits for a request.
- XFER drives the port strobe for one cycle and captures the port read data.
- SKIP stands in for XFER when the address misses the window.
- RESP pulses the completion.

The controller has five transitions:

| Transition | From | To | Condition |
|---|---|---|---|
| ISSUE | IDLE | XFER | request inside the window |
| REJECT | IDLE | SKIP | request outside the window |
| CAPTURE | XFER | RESP | unconditional |
| SKIPPED | SKIP | RESP | unconditional |
| RETIRE | RESP | IDLE | unconditional |

Top module: `iowin_bridge`

## Requirements
- R1: A request is forwarded to the port bus only if its address lies from 0x80000000 through 0x807FFFFF inclusive.
- R2: With `map_sparse` = 0 at acceptance, `port_addr` equals request address bits 15:0.
- R3: With `map_sparse` = 1 at acceptance, `port_addr` bits 4:0 equal address bits 4:0, bits 15:5 equal address bits 22:12, and the 16-bit result is the low 5 address bits ORed with address bits 26:12 shifted right by 7.
- R4: Size code 0 (byte) moves only byte lane 7:0, never swapped, and drives zero in bits 31:8 in both directions.
- R5: Size code 1 (half-word) with `big_endian` = 1 exchanges bits 15:8 and 7:0 in both directions, and drives bits 31:16 as zero.
- R6: Size codes 2 and 3 (word) with `big_endian` = 1 reverse all four byte lanes in both directions.
- R7: With `big_endian` = 0, half-word and word data pass unswapped, and a half-word still drives bits 31:16 as zero.
- R8: A request accepted in IDLE at a clock edge raises `port_valid` for exactly the next cycle, and `rsp_done` for exactly the cycle after that.
- R9: An out-of-window request never raises `port_valid`; `rsp_done` pulses in the same cycle it would for a hit, with `rsp_miss` = 1 and `rsp_rdata` = 0.
- R10: `req_valid` is sampled only in IDLE, so requests held or presented in XFER, SKIP or RESP are ignored. Mode inputs changed after acceptance do not affect the access in flight.
- R11: While `rst_n` is low, `port_valid`, `port_we`, `rsp_done`, `rsp_miss` and `rsp_rdata` are all zero.
- R12: A write drives `port_we` = 1 together with `port_valid`, and returns `rsp_rdata` = 0 on its completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_addr | input | 32 | Processor physical address |
| req_size | input | 2 | 0 byte, 1 half-word, 2 or 3 word |
| req_we | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Right-justified write data |
| map_sparse | input | 1 | Map mode: 0 dense, 1 sparse page packing |
| big_endian | input | 1 | Processor side is big-endian; enables lane swapping |
| port_valid | output | 1 | Port-bus cycle strobe |
| port_we | output | 1 | Port-bus write strobe |
| port_addr | output | 16 | Translated port address |
| port_size | output | 2 | Size code of the port cycle |
| port_wdata | output | 32 | Lane-corrected write data |
| port_rdata | input | 32 | Read data from the port bus, valid with `port_valid` |
| rsp_done | output | 1 | Completion pulse |
| rsp_miss | output | 1 | Request was outside the window |
| rsp_rdata | output | 32 | Lane-corrected read data, valid with `rsp_done` |

## Verification
Two things can fall in the same cycle.

The first is request acceptance together with a change of the mode inputs. The bench flips `map_sparse` and `big_endian` in the cycle right after each request is accepted, while the access is still in XFER. Its reference model has already latched the modes, so any late sampling shows up as a wrong port address or wrong swapped data.

The second is a request arriving while the completion pulse is out. The bench holds `req_valid` high with a new address every cycle. The reference model accepts only when its own idle phase allows it, so a request taken in RESP or XFER shows up as an unexpected strobe or address.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'd0,
        SZ_HALF     = 2'd1,
        SZ_WORD     = 2'd2,
        SZ_WORD_ALT = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_SKIP,
        ST_RESP
    } bridge_state_e;

    function automatic int unsigned size_bytes(input logic [1:0] code);
        unique case (acc_size_e'(code))
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/iowin_addr_xlate.sv
module iowin_addr_xlate #(
    parameter int ADDR_W = 32,
    parameter int PORT_AW = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000,
    parameter int WIN_LOG2 = 23,
    parameter int FINE_BITS = 5,
    parameter int PAGE_LO = 12,
    parameter int PAGE_HI = 26,
    parameter int COMPACT_SHIFT = 7
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               sparse,
    output logic               hit,
    output logic [PORT_AW-1:0] port_addr
);
    localparam logic [ADDR_W-1:0] FINE_MASK = (ADDR_W'(1) << FINE_BITS) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PAGE_MASK =
        ((ADDR_W'(1) << (PAGE_HI - PAGE_LO + 1)) - ADDR_W'(1)) << PAGE_LO;

    logic [PORT_AW-1:0] packed_addr;

    always_comb begin
        hit         = (addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
        packed_addr = PORT_AW'((addr & FINE_MASK) | ((addr & PAGE_MASK) >> COMPACT_SHIFT));
        port_addr   = sparse ? packed_addr : addr[PORT_AW-1:0];
    end
endmodule

// File: rtl/iowin_lane_swap.sv
module iowin_lane_swap
    import iowin_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        size,
    input  logic              swap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int LANES = DATA_W / 8;

    int unsigned nb;

    always_comb begin
        nb = size_bytes(size);
        if (nb > LANES) nb = LANES;
        dout = '0;
        for (int i = 0; i < LANES; i++) begin
            if (i < int'(nb)) begin
                if (swap_en)
                    dout[i*8 +: 8] = din[(int'(nb) - 1 - i)*8 +: 8];
                else
                    dout[i*8 +: 8] = din[i*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/iowin_ctrl.sv
module iowin_ctrl
    import iowin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_hit,
    output logic accept,
    output logic capture,
    output logic fwd_strobe,
    output logic done_pulse
);
    bridge_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = req_hit ? ST_XFER : ST_SKIP; // ISSUE / REJECT
            ST_XFER: state_nx = ST_RESP;                                    // CAPTURE
            ST_SKIP: state_nx = ST_RESP;                                    // SKIPPED
            ST_RESP: state_nx = ST_IDLE;                                    // RETIRE
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        accept     = 1'b0;
        capture    = 1'b0;
        fwd_strobe = 1'b0;
        done_pulse = 1'b0;
        unique case (state)
            ST_IDLE: accept = req_valid;
            ST_XFER: begin
                fwd_strobe = 1'b1;
                capture    = 1'b1;
            end
            ST_SKIP: ;
            ST_RESP: done_pulse = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/iowin_bridge.sv
module iowin_bridge #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int PORT_AW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_size,
    input  logic               req_we,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic               map_sparse,
    input  logic               big_endian,
    output logic               port_valid,
    output logic               port_we,
    output logic [PORT_AW-1:0] port_addr,
    output logic [1:0]         port_size,
    output logic [DATA_W-1:0]  port_wdata,
    input  logic [DATA_W-1:0]  port_rdata,
    output logic               rsp_done,
    output logic               rsp_miss,
    output logic [DATA_W-1:0]  rsp_rdata
);
    logic               accept, capture, fwd_strobe, done_pulse;
    logic               hit_c;
    logic [PORT_AW-1:0] xl_addr_c;

    logic [PORT_AW-1:0] addr_q;
    logic [DATA_W-1:0]  wdata_q, rdata_raw_q;
    logic [1:0]         size_q;
    logic               we_q, be_q, miss_q;
    logic [DATA_W-1:0]  wdata_sw, rdata_sw;

    iowin_addr_xlate #(.ADDR_W(ADDR_W), .PORT_AW(PORT_AW)) u_xlate (
        .addr      (req_addr),
        .sparse    (map_sparse),
        .hit       (hit_c),
        .port_addr (xl_addr_c)
    );

    iowin_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_hit    (hit_c),
        .accept     (accept),
        .capture    (capture),
        .fwd_strobe (fwd_strobe),
        .done_pulse (done_pulse)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= '0;
            wdata_q     <= '0;
            rdata_raw_q <= '0;
            size_q      <= '0;
            we_q        <= 1'b0;
            be_q        <= 1'b0;
            miss_q      <= 1'b0;
        end else if (accept) begin
            addr_q      <= xl_addr_c;
            wdata_q     <= req_wdata;
            rdata_raw_q <= '0;
            size_q      <= req_size;
            we_q        <= req_we;
            be_q        <= big_endian;
            miss_q      <= !hit_c;
        end else if (capture && !we_q) begin
            rdata_raw_q <= port_rdata;
        end
    end

    iowin_lane_swap #(.DATA_W(DATA_W)) u_wswap (
        .size (size_q), .swap_en (be_q), .din (wdata_q), .dout (wdata_sw)
    );

    iowin_lane_swap #(.DATA_W(DATA_W)) u_rswap (
        .size (size_q), .swap_en (be_q), .din (rdata_raw_q), .dout (rdata_sw)
    );

    always_comb begin
        port_valid = fwd_strobe;
        port_we    = fwd_strobe & we_q;
        port_addr  = addr_q;
        port_size  = size_q;
        port_wdata = wdata_sw;
        rsp_done   = done_pulse;
        rsp_miss   = done_pulse & miss_q;
        rsp_rdata  = done_pulse ? rdata_sw : '0;
    end
endmodule

// File: rtl/iowin_bridge_chk.sv
module iowin_bridge_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              port_valid,
    input logic              rsp_done,
    input logic              rsp_miss,
    input logic [DATA_W-1:0] rsp_rdata
);
    AST_FWD_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        port_valid |=> (rsp_done && !rsp_miss)); // R8
    AST_FWD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        port_valid |=> !port_valid); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R8
    AST_DONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> ($past(port_valid) || rsp_miss)); // R8
    AST_MISS_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_miss) |-> !$past(port_valid)); // R9
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_rdata == '0)); // R9
endmodule

bind iowin_bridge iowin_bridge_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_valid (port_valid),
    .rsp_done   (rsp_done),
    .rsp_miss   (rsp_miss),
    .rsp_rdata  (rsp_rdata)
);

// File: tb/iowin_bridge_tb.sv
`timescale 1ns/1ps
module iowin_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_we = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        map_sparse = 1'b0;
    logic        big_endian = 1'b0;
    logic        port_valid, port_we, rsp_done, rsp_miss;
    logic [15:0] port_addr;
    logic [1:0]  port_size;
    logic [31:0] port_wdata, port_rdata, rsp_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string scen = "reset";

    always #2 clk = ~clk;

    // port-side device model: data derived from the address it sees
    assign port_rdata = {port_addr ^ 16'hC3A5, port_addr};

    iowin_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_we(req_we), .req_wdata(req_wdata),
        .map_sparse(map_sparse), .big_endian(big_endian),
        .port_valid(port_valid), .port_we(port_we), .port_addr(port_addr),
        .port_size(port_size), .port_wdata(port_wdata), .port_rdata(port_rdata),
        .rsp_done(rsp_done), .rsp_miss(rsp_miss), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [31:0] m_lane(input logic [1:0] s, input logic be, input logic [31:0] d);
        case (s)
            2'd0:    m_lane = {24'h0, d[7:0]};
            2'd1:    m_lane = be ? {16'h0, d[7:0], d[15:8]} : {16'h0, d[15:0]};
            default: m_lane = be ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
        endcase
    endfunction

    function automatic logic [15:0] m_port(input logic [31:0] a, input logic sp);
        longint v;
        if (sp) begin
            v = longint'(a & 32'h1F) + longint'((a >> 12) & 32'h7FF) * 32;
            m_port = v[15:0];
        end else begin
            m_port = a[15:0];
        end
    endfunction

    function automatic string size_tag(input logic [1:0] s, input logic be);
        if (!be) return (s == 2'd0) ? "R4" : "R7";
        if (s == 2'd0) return "R4";
        if (s == 2'd1) return "R5";
        return "R6";
    endfunction

    // behavioural reference: phase 0 idle, 1 port cycle, 2 completion
    int          ph = 0;
    logic [31:0] m_a, m_wd;
    logic [1:0]  m_s;
    logic        m_we, m_sp, m_be, m_hit;

    always @(posedge clk) begin
        if (!rst_n) ph = 0;
        else if (ph == 0) begin
            if (req_valid) begin
                m_a = req_addr; m_wd = req_wdata; m_s = req_size; m_we = req_we;
                m_sp = map_sparse; m_be = big_endian;
                m_hit = (req_addr >= 32'h8000_0000) && (req_addr <= 32'h807F_FFFF);
                ph = 1;
            end
        end else if (ph == 1) ph = 2;
        else ph = 0;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) actual=%h expected=%h at %0t", tag, scen, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic [15:0] ea;
        if (!rst_n) begin
            chk("R11 port_valid", 32'(port_valid), 0);
            chk("R11 port_we", 32'(port_we), 0);
            chk("R11 rsp_done", 32'(rsp_done), 0);
            chk("R11 rsp_miss", 32'(rsp_miss), 0);
            chk("R11 rsp_rdata", rsp_rdata, 0);
        end else begin
            chk((ph == 1 && !m_hit) ? "R9 port_valid" : "R8/R1 port_valid",
                32'(port_valid), 32'((ph == 1) && m_hit));
            chk("R8 rsp_done", 32'(rsp_done), 32'(ph == 2));
            chk("R9 rsp_miss", 32'(rsp_miss), 32'((ph == 2) && !m_hit));
            if (ph == 1 && m_hit) begin
                ea = m_port(m_a, m_sp);
                chk("R12 port_we", 32'(port_we), 32'(m_we));
                chk(m_sp ? "R3 port_addr" : "R2 port_addr", 32'(port_addr), 32'(ea));
                if (m_we) chk({size_tag(m_s, m_be), " port_wdata"}, port_wdata, m_lane(m_s, m_be, m_wd));
            end
            if (ph == 2) begin
                ea = m_port(m_a, m_sp);
                if (!m_hit)     chk("R9 rsp_rdata", rsp_rdata, 0);
                else if (m_we)  chk("R12 rsp_rdata", rsp_rdata, 0);
                else            chk({size_tag(m_s, m_be), " rsp_rdata"}, rsp_rdata,
                                    m_lane(m_s, m_be, {ea ^ 16'hC3A5, ea}));
            end
        end
    end

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    task automatic issue(input logic [31:0] a, input logic [1:0] s, input logic we,
                         input logic [31:0] wd, input logic sp, input logic be);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = s; req_we = we; req_wdata = wd;
        map_sparse = sp; big_endian = be;
        @(negedge clk);
        req_valid = 1'b0;
        map_sparse = ~sp; big_endian = ~be;   // R10: late mode change ignored
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        scen = "R2 dense reads";
        issue(32'h8000_0000, 2'd0, 1'b0, 0, 1'b0, 1'b1);
        issue(32'h8000_1234, 2'd1, 1'b0, 0, 1'b0, 1'b1);
        issue(32'h8000_ABCC, 2'd2, 1'b0, 0, 1'b0, 1'b1);
        issue(32'h807F_FFFF, 2'd3, 1'b0, 0, 1'b0, 1'b0);
        scen = "R7 little-endian";
        issue(32'h8000_0102, 2'd1, 1'b0, 0, 1'b0, 1'b0);
        issue(32'h8000_0104, 2'd2, 1'b1, 32'h1122_3344, 1'b0, 1'b0);
        scen = "R3 sparse map";
        issue(32'h8000_3015, 2'd0, 1'b0, 0, 1'b1, 1'b1);
        issue(32'h807F_F01F, 2'd2, 1'b0, 0, 1'b1, 1'b1);
        issue(32'h8055_5AAA, 2'd1, 1'b1, 32'hDEAD_BEEF, 1'b1, 1'b1);
        scen = "R5 R6 R12 writes";
        issue(32'h8000_0300, 2'd1, 1'b1, 32'hFFFF_A1B2, 1'b0, 1'b1);
        issue(32'h8000_0304, 2'd2, 1'b1, 32'hA1B2_C3D4, 1'b0, 1'b1);
        issue(32'h8000_0308, 2'd0, 1'b1, 32'h1234_5678, 1'b0, 1'b1);
        scen = "R1 R9 window edges";
        issue(32'h7FFF_FFFF, 2'd2, 1'b0, 0, 1'b0, 1'b1);
        issue(32'h8080_0000, 2'd0, 1'b1, 32'h55, 1'b0, 1'b0);
        issue(32'h0000_1234, 2'd1, 1'b0, 0, 1'b1, 1'b1);
        issue(32'hFFFF_FFFF, 2'd2, 1'b0, 0, 1'b0, 1'b0);
        scen = "R10 held request";
        @(negedge clk);
        req_valid = 1'b1;
        for (int i = 0; i < 40; i++) begin
            req_addr = 32'h8000_0000 + 32'(i * 32'h1013);
            req_size = 2'(i); req_we = i[0]; req_wdata = 32'hC0DE_0000 + 32'(i);
            map_sparse = i[1]; big_endian = i[2];
            @(negedge clk);
        end
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        scen = "random";
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            a = $urandom;
            if ((i % 4) != 0) a = {9'b1000_0000_0, a[22:0]};
            issue(a, 2'($urandom), 1'($urandom), $urandom, 1'($urandom), 1'($urandom));
        end
        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule